// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block sits between a memory controller's command scheduler and the SDRAM pins. It holds the programmed mode settings (burst length, burst ordering, read latency and write-burst policy), which it decodes from a packed mode word. For each column read or write command it steps through the beats of the burst and presents one column address per cycle. A read data-valid strobe follows each read beat after the programmed latency, and a write data-valid strobe marks each write beat.

A column command may arrive on any cycle, including while a burst is still running. The new command drops every beat of the old burst that has not yet been presented, and it starts a full-length burst from its own address. Read strobes for beats already presented still emerge after their latency.

A small state machine drives the sequencing. It has two states: `S_IDLE` (no burst) and `S_BURST` (one beat presented each cycle). Its transitions are:

- START, from `S_IDLE` to `S_BURST`, on a command.
- RESTART, from `S_BURST` to `S_BURST`, on a command. The burst is interrupted.
- STEP, from `S_BURST` to `S_BURST`, while beats remain.
- DONE, from `S_BURST` to `S_IDLE`, after the last beat when no command arrives.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, no burst is active (`addr_valid`, `rd_dv`, `wr_dv` and `mode_err` are 0). The settings are burst length 1, sequential ordering, read latency 2 and burst writes.
- R2: Mode bits [2:0] set the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. The first beat address appears on the cycle after the command is sampled, and one beat follows on each later cycle.
- R3: With mode bit 3 = 0 (sequential), beat i has low bits (start + i) mod length within the length-aligned group. Column bits above the group stay fixed for the whole burst.
- R4: With mode bit 3 = 1 (interleaved), beat i has low bits start XOR i within the length-aligned group.
- R5: Mode bits [6:4] = 010 or 011 set the read latency to 2 or 3. `rd_dv` pulses exactly that many cycles after each read beat's address.
- R6: `wr_dv` is high on exactly the cycles that present a write beat address.
- R7: With mode bit 9 = 1, every write is a single beat and reads still use the programmed length. With bit 9 = 0, writes burst like reads.
- R8: A command sampled during a burst drops the remaining beats. The next cycle presents the new address, followed by a full-length burst. Read strobes for beats already presented still appear.
- R9: A mode write with a burst-length code of 1xx, a latency code other than 010 or 011, any of bits [11:10] set, or a nonzero bank field sets `mode_err` and keeps all previous settings. A valid mode write clears `mode_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_word | input | MODE_W (12) | Packed mode word |
| mode_bank | input | BANK_W (2) | Bank-select field accompanying the mode write; must be zero |
| cmd_valid | input | 1 | Column command strobe |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_col | input | COL_W (10) | Starting column address |
| col_addr | output | COL_W (10) | Column address of the current beat |
| addr_valid | output | 1 | A beat address is presented this cycle |
| rd_dv | output | 1 | Read data valid, delayed by the read latency |
| wr_dv | output | 1 | Write data valid, aligned with the write beat |
| mode_err | output | 1 | The last mode write was rejected |

## Verification
A command sampled at clock edge E gives beat 0 in the cycle after E and beat i i cycles later. The matching read strobe comes latency cycles after that, and the write strobe comes in the same cycle. A mode write takes effect, and updates `mode_err`, in the cycle after its edge. Each scenario task issues its stimulus just after an edge and samples one time unit after each following edge. It compares every cycle against a table built from these offsets, so an early or late beat or strobe shows as a miscompare on that exact cycle. The tasks also run enough cycles past the burst to confirm that the outputs fall quiet afterwards.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_BURST = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic [1:0] bl_log;     // log2 of burst length
        logic       interleave;
        logic [1:0] cas;        // 2 or 3
        logic       wr_single;
    } mode_cfg_t;

    localparam int BL_LSB  = 0;
    localparam int BT_BIT  = 3;
    localparam int CL_LSB  = 4;
    localparam int WB_BIT  = 9;
    localparam int TOP_LSB = 10;

    localparam mode_cfg_t CFG_RESET = '{bl_log: 2'd0, interleave: 1'b0,
                                        cas: 2'd2, wr_single: 1'b0};

    function automatic logic [2:0] len_mask(input logic [1:0] lg);
        unique case (lg)
            2'd0: len_mask = 3'b000;
            2'd1: len_mask = 3'b001;
            2'd2: len_mask = 3'b011;
            default: len_mask = 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
    import sbs_pkg::*;
#(
    parameter int MODE_W = 12,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [BANK_W-1:0] mode_bank,
    output mode_cfg_t         cfg,
    output logic              mode_err
);
    logic [2:0] bl_code;
    logic [2:0] cl_code;
    logic       word_ok;

    always_comb begin
        bl_code = mode_word[BL_LSB +: 3];
        cl_code = mode_word[CL_LSB +: 3];
        word_ok = !bl_code[2]
               && (cl_code == 3'b010 || cl_code == 3'b011)
               && (mode_word[MODE_W-1:TOP_LSB] == '0)
               && (mode_bank == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= CFG_RESET;
            mode_err <= 1'b0;
        end else if (mode_we) begin
            if (word_ok) begin
                cfg.bl_log     <= bl_code[1:0];
                cfg.interleave <= mode_word[BT_BIT];
                cfg.cas        <= cl_code[1:0];
                cfg.wr_single  <= mode_word[WB_BIT];
                mode_err       <= 1'b0;
            end else begin
                mode_err       <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbs_addr_gen.sv
module sbs_addr_gen #(
    parameter int COL_W = 10,
    parameter int CNT_W = 3
) (
    input  logic [COL_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    input  logic [CNT_W-1:0] mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [CNT_W-1:0] low_seq;
    logic [CNT_W-1:0] low_il;
    logic [CNT_W-1:0] low_sel;

    always_comb begin
        low_seq = start[CNT_W-1:0] + beat;
        low_il  = start[CNT_W-1:0] ^ beat;
        low_sel = interleave ? low_il : low_seq;
        col     = {start[COL_W-1:CNT_W],
                   (start[CNT_W-1:0] & ~mask) | (low_sel & mask)};
    end
endmodule

// File: rtl/sbs_lat_pipe.sv
module sbs_lat_pipe #(
    parameter int MAX_CL = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_beat,
    input  logic [1:0] cas,
    output logic       rd_dv
);
    logic [MAX_CL:1] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[MAX_CL-1:1], rd_beat};
    end

    always_comb begin
        rd_dv = 1'b0;
        for (int k = 1; k <= MAX_CL; k++)
            if (int'(cas) == k) rd_dv = pipe[k];
    end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sbs_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int MODE_W = 12,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [BANK_W-1:0] mode_bank,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  cmd_col,
    output logic [COL_W-1:0]  col_addr,
    output logic              addr_valid,
    output logic              rd_dv,
    output logic              wr_dv,
    output logic              mode_err
);
    localparam int CNT_W  = 3;
    localparam int MAX_CL = 3;

    mode_cfg_t  cfg;
    seq_state_t state_q, state_d;

    logic [CNT_W-1:0] cnt_q, last_q;
    logic [COL_W-1:0] start_q;
    logic             il_q, wr_q;
    logic [1:0]       cas_q;
    logic [1:0]       len_log;
    logic             rd_beat;

    sbs_mode_reg #(.MODE_W(MODE_W), .BANK_W(BANK_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_we  (mode_we),
        .mode_word(mode_word),
        .mode_bank(mode_bank),
        .cfg      (cfg),
        .mode_err (mode_err)
    );

    // Next-state logic: START / RESTART / STEP / DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = cmd_valid ? S_BURST : S_IDLE;
            S_BURST: state_d = (cmd_valid || cnt_q != last_q) ? S_BURST : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign len_log = (cmd_write && cfg.wr_single) ? 2'd0 : cfg.bl_log;

    // Burst context, latched per command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            last_q  <= '0;
            start_q <= '0;
            il_q    <= 1'b0;
            wr_q    <= 1'b0;
            cas_q   <= 2'd2;
        end else if (cmd_valid) begin
            cnt_q   <= '0;
            last_q  <= len_mask(len_log);
            start_q <= cmd_col;
            il_q    <= cfg.interleave;
            wr_q    <= cmd_write;
            cas_q   <= cfg.cas;
        end else if (state_q == S_BURST) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Output process
    always_comb begin
        addr_valid = (state_q == S_BURST);
        wr_dv      = addr_valid && wr_q;
        rd_beat    = addr_valid && !wr_q;
    end

    sbs_addr_gen #(.COL_W(COL_W), .CNT_W(CNT_W)) u_addr (
        .start     (start_q),
        .beat      (cnt_q),
        .mask      (last_q),
        .interleave(il_q),
        .col       (col_addr)
    );

    sbs_lat_pipe #(.MAX_CL(MAX_CL)) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_beat(rd_beat),
        .cas    (cas_q),
        .rd_dv  (rd_dv)
    );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int COL_W  = 10,
    parameter int MODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_we,
    input logic [MODE_W-1:0] mode_word,
    input logic              cmd_valid,
    input logic [COL_W-1:0]  cmd_col,
    input logic [COL_W-1:0]  col_addr,
    input logic              addr_valid,
    input logic              wr_dv,
    input logic              mode_err
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(addr_valid) && !$past(cmd_valid)) |-> !addr_valid); // R2

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && $past(addr_valid) && !$past(cmd_valid))
        |-> (col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3]))); // R3

    AST_WR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dv |-> addr_valid); // R6

    AST_CMD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (addr_valid && col_addr == $past(cmd_col))); // R8

    AST_BAD_LEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_word[2]) |=> mode_err); // R9
endmodule

bind sdram_burst_seq sbs_checker #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .mode_word (mode_word),
    .cmd_valid (cmd_valid),
    .cmd_col   (cmd_col),
    .col_addr  (col_addr),
    .addr_valid(addr_valid),
    .wr_dv     (wr_dv),
    .mode_err  (mode_err)
);

// File: tb/tb_sdram_burst_seq.sv
module tb_sdram_burst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [11:0] mode_word = '0;
    logic [1:0]  mode_bank = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [9:0]  cmd_col = '0;
    logic [9:0]  col_addr;
    logic        addr_valid, rd_dv, wr_dv, mode_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdram_burst_seq dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int mw(int bl, int bt, int cl, int wb);
        return (wb << 9) | (cl << 4) | (bt << 3) | bl;
    endfunction

    function automatic int exp_col(int start, int i, int len, bit il);
        int m = len - 1;
        int low = il ? ((start ^ i) & m) : ((start + i) & m);
        return (start & ~m & 1023) | low;
    endfunction

    task automatic write_mode(input int word, input int bank);
        mode_we = 1'b1; mode_word = 12'(word); mode_bank = 2'(bank);
        @(posedge clk); #1;
        mode_we = 1'b0; mode_bank = '0;
    endtask

    // One burst, sampled every cycle until strobes drain
    task automatic run_burst(input bit wr, input int start, input int len,
                             input int cl, input bit il, input string req);
        cmd_valid = 1'b1; cmd_write = wr; cmd_col = 10'(start);
        for (int i = 0; i < len + cl + 2; i++) begin
            @(posedge clk); #1;
            if (i == 0) cmd_valid = 1'b0;
            chk(req, int'(addr_valid), int'(i < len));
            if (i < len) chk(req, int'(col_addr), exp_col(start, i, len, il));
            chk(req, int'(wr_dv), int'(wr && i < len));
            chk(req, int'(rd_dv), int'(!wr && i >= cl && i < cl + len));
        end
    endtask

    // Burst 1 interrupted by burst 2 after k beats
    task automatic interrupt(input bit wr1, input int s1, input bit wr2, input int s2,
                             input int k, input int len, input int cl, input bit il,
                             input string req);
        cmd_valid = 1'b1; cmd_write = wr1; cmd_col = 10'(s1);
        for (int i = 0; i < k + len + cl + 2; i++) begin
            int j;
            bit rdb;
            @(posedge clk); #1;
            if (i == 0) cmd_valid = 1'b0;
            if (i == k) cmd_valid = 1'b0;
            chk(req, int'(addr_valid), int'(i < k + len));
            if (i < k) begin
                chk(req, int'(col_addr), exp_col(s1, i, len, il));
                chk(req, int'(wr_dv), int'(wr1));
            end else if (i < k + len) begin
                chk(req, int'(col_addr), exp_col(s2, i - k, len, il));
                chk(req, int'(wr_dv), int'(wr2));
            end
            j = i - cl;
            rdb = (j >= 0) && ((j < k && !wr1) || (j >= k && j < k + len && !wr2));
            chk(req, int'(rd_dv), int'(rdb));
            if (i == k - 1) begin
                cmd_valid = 1'b1; cmd_write = wr2; cmd_col = 10'(s2);
            end
        end
    endtask

    task automatic t_reset();
        chk("R1", int'(addr_valid), 0);
        chk("R1", int'(rd_dv), 0);
        chk("R1", int'(wr_dv), 0);
        chk("R1", int'(mode_err), 0);
        run_burst(1'b0, 5, 1, 2, 1'b0, "R1");   // default: BL1, CL2
        run_burst(1'b1, 9, 1, 2, 1'b0, "R1");
    endtask

    task automatic t_sequential();
        write_mode(mw(2, 0, 2, 0), 0);
        run_burst(1'b0, 14, 4, 2, 1'b0, "R3");
        run_burst(1'b0, 17, 4, 2, 1'b0, "R2");
    endtask

    task automatic t_interleave();
        write_mode(mw(3, 1, 3, 0), 0);
        run_burst(1'b0, 29, 8, 3, 1'b1, "R4");  // also R5 latency 3
        run_burst(1'b0, 6, 8, 3, 1'b1, "R5");
    endtask

    task automatic t_write();
        write_mode(mw(1, 0, 3, 0), 0);
        run_burst(1'b1, 1023, 2, 3, 1'b0, "R6");
        write_mode(mw(3, 0, 2, 0), 0);
        run_burst(1'b1, 12, 8, 2, 1'b0, "R7");  // bit9=0: writes burst
    endtask

    task automatic t_single_write();
        write_mode(mw(3, 0, 2, 1), 0);
        run_burst(1'b1, 16, 1, 2, 1'b0, "R7");
        run_burst(1'b0, 16, 8, 2, 1'b0, "R7");
    endtask

    task automatic t_interrupt();
        write_mode(mw(3, 0, 2, 0), 0);
        interrupt(1'b0, 0, 1'b0, 64, 3, 8, 2, 1'b0, "R8");
        interrupt(1'b0, 6, 1'b1, 33, 2, 8, 2, 1'b0, "R8");
        interrupt(1'b1, 100, 1'b0, 200, 1, 8, 2, 1'b0, "R8");
    endtask

    task automatic t_reserved();
        write_mode(mw(4, 1, 3, 1), 0);
        chk("R9", int'(mode_err), 1);
        run_burst(1'b0, 3, 8, 2, 1'b0, "R9");   // previous settings kept
        write_mode(mw(2, 0, 0, 0), 0);
        chk("R9", int'(mode_err), 1);
        write_mode(mw(2, 0, 2, 0) | (1 << 10), 0);
        chk("R9", int'(mode_err), 1);
        write_mode(mw(2, 0, 2, 0), 1);
        chk("R9", int'(mode_err), 1);
        run_burst(1'b1, 40, 8, 2, 1'b0, "R9");
        write_mode(mw(0, 0, 3, 0), 0);
        chk("R9", int'(mode_err), 0);
        run_burst(1'b0, 7, 1, 3, 1'b0, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_sequential();
        t_interleave();
        t_write();
        t_single_write();
        t_interrupt();
        t_reserved();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule